// File: doc/BRIEF.md
# Receive Descriptor Walker with Word-Packing Write Path

This block is the receive side of a descriptor-driven Ethernet MAC. Once its enable input is high it looks at the receive descriptor selected by its current index. A descriptor is two words in a table: an even-indexed status word and the odd word after it, which holds the buffer address. When the status word marks the descriptor as free for hardware, the engine claims it. It then takes one frame from a byte-stream input with a valid/ready handshake and packs the bytes into 32-bit words. Each word goes to memory at the buffer address plus the byte offset of that word.

At the end of the frame the engine writes one status word back to the descriptor. That word carries the received length, the owner bit cleared, and the length-limit flags. The engine then steps to the next descriptor and raises a completion event. The interrupt output follows that event only when its mask is set. A frame too short to hold an Ethernet header is dropped: its descriptor is neither released nor advanced past. The descriptor table itself, the interrupt-source register and the write-one-to-clear logic sit outside this block. They see the engine only through its table port and its event pulses.

Receive descriptors form a ring that starts at a base index, the count of transmit descriptors placed ahead of them in the same table. The ring returns to that base, not to zero.

Top module: `rxdesc_engine`

## Requirements
- R1: While `rx_enable` is low in the idle state, the engine accepts no bytes (`rx_ready` low). It issues no memory writes, no descriptor writes and no busy events.
- R2: While the engine is idle and disabled, its descriptor index follows `base_idx`. After enabling, the first descriptor it examines is the one at `base_idx`.
- R3: A descriptor whose status bit 15 (owner: 1 = free for hardware) is clear is not claimed. In every cycle the engine waits on such a descriptor while `rx_valid` is high, `evt_busy` is high.
- R4: Bytes are packed most significant byte first (byte 4k+0 in bits 31:24). Word k is written to the buffer address plus 4k.
- R5: When the frame length is not a multiple of 4, the unused low bytes of the final word are written as zero. No word past the final one is written.
- R6: On completion, the written-back status holds the byte count in bits 31:16 and clears bit 15. It clears the error flags in bits 6:0 that were present when the descriptor was claimed, and keeps bits 14:7 (including the wrap bit 13) as they were.
- R7: Status bit 1 is set when the length is below `min_len`. Bit 2 is set when the length is above `max_len`.
- R8: A frame of fewer than 14 bytes gives no descriptor write and no completion event, and leaves the index unchanged. The engine returns to idle and can then reclaim the same descriptor.
- R9: After a write-back the index advances by 2. It returns to `base_idx` instead when status bit 13 (wrap) is set or when the index is at or past BD_WORDS-2.
- R10: `evt_rxf` pulses for one cycle with each descriptor write-back. `irq` pulses with it only when `rxf_mask` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receive enable from the mode register |
| base_idx | input | IDX_W | First receive descriptor word index (transmit descriptor count) |
| min_len | input | 16 | Minimum frame length for the short flag |
| max_len | input | 16 | Maximum frame length for the long flag |
| rxf_mask | input | 1 | Mask bit enabling the interrupt on frame completion |
| rx_valid | input | 1 | Byte-stream valid |
| rx_data | input | 8 | Byte-stream data |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_ready | output | 1 | Byte accepted when high together with rx_valid |
| desc_idx | output | IDX_W | Word index of the current descriptor status word |
| desc_status | input | 32 | Table word at desc_idx |
| desc_bufaddr | input | ADDR_W | Table word at desc_idx+1 |
| desc_wr_en | output | 1 | Write desc_wr_data to the table at desc_idx |
| desc_wr_data | output | 32 | Status word written back on completion |
| mem_wr_en | output | 1 | Memory word write strobe |
| mem_wr_addr | output | ADDR_W | Byte address of the memory word |
| mem_wr_data | output | 32 | Packed memory word |
| evt_busy | output | 1 | Frame pending with no free descriptor |
| evt_rxf | output | 1 | Frame completed and descriptor released |
| irq | output | 1 | Masked completion interrupt |

## Verification
On every cycle the assertions check a set of local invariants. The engine must stay closed to bytes after an idle cycle with enable low. A busy event must never coincide with byte acceptance or write-back. Memory words must be aligned, and every write-back must clear the owner bit and carry a length of at least the header size. A dropped short frame must be followed by no write-back, and the index must move only by two or back to the base. Only the bench scenarios can show the packed byte order, the zero fill of a partial last word, and the exact flag values for each length against the limits. The same holds for which ring position a wrap-marked or end-of-table descriptor hands over to, and for the reload of the index from a new base after a disable.

// File: rtl/rxdesc_pkg.sv
package rxdesc_pkg;

  localparam int LEN_W     = 16;
  localparam int OWN_POS   = 15;
  localparam int WRAP_POS  = 13;
  localparam int SHORT_POS = 1;
  localparam int LONG_POS  = 2;
  localparam logic [31:0] ERR_FLAGS = 32'h0000_007F;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEEK,
    ST_RECV,
    ST_CLOSE
  } rx_state_e;

  // status as held after claiming: error flags dropped
  function automatic logic [31:0] claim_status(input logic [31:0] st);
    return st & ~ERR_FLAGS;
  endfunction

  // status written back at frame end
  function automatic logic [31:0] close_status(input logic [31:0] st,
                                               input logic [LEN_W-1:0] len,
                                               input logic is_short,
                                               input logic is_long);
    logic [31:0] r;
    r            = {len, st[15:0]};
    r[OWN_POS]   = 1'b0;
    r[SHORT_POS] = is_short;
    r[LONG_POS]  = is_long;
    return r;
  endfunction

  // lane 0 lands in the top byte
  function automatic logic [31:0] place_byte(input logic [31:0] acc,
                                             input logic [7:0]  b,
                                             input logic [1:0]  lane);
    return acc | ({24'd0, b} << (5'd24 - {lane, 3'b000}));
  endfunction

  function automatic logic [LEN_W-1:0] word_offset(input logic [LEN_W-1:0] cnt);
    return {cnt[LEN_W-1:2], 2'b00};
  endfunction

endpackage

// File: rtl/rxdesc_index.sv
module rxdesc_index #(
  parameter int BD_WORDS = 256,
  parameter int IDX_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             advance,
  input  logic             wrap_bit,
  input  logic [IDX_W-1:0] base_idx,
  output logic [IDX_W-1:0] cur_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BD_WORDS - 2);

  logic             at_end;
  logic [IDX_W-1:0] step_to;

  assign at_end  = (cur_idx >= LAST_IDX);
  assign step_to = (wrap_bit || at_end) ? base_idx : cur_idx + IDX_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_idx <= '0;
    else if (reload)  cur_idx <= base_idx;
    else if (advance) cur_idx <= step_to;
  end
endmodule

// File: rtl/rxdesc_packer.sv
module rxdesc_packer
  import rxdesc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              accept,
  input  logic [7:0]        byte_in,
  input  logic              last_in,
  input  logic [ADDR_W-1:0] buf_addr,
  output logic [LEN_W-1:0]  byte_cnt,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data
);
  logic [31:0] acc;
  logic [31:0] merged;
  logic        word_done;

  assign merged    = place_byte(acc, byte_in, byte_cnt[1:0]);
  assign word_done = (byte_cnt[1:0] == 2'd3) || last_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_cnt    <= '0;
      acc         <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
    end else begin
      mem_wr_en <= 1'b0;
      if (start) begin
        byte_cnt <= '0;
        acc      <= '0;
      end else if (accept) begin
        byte_cnt <= byte_cnt + LEN_W'(1);
        if (word_done) begin
          mem_wr_en   <= 1'b1;
          mem_wr_addr <= buf_addr + ADDR_W'(word_offset(byte_cnt));
          mem_wr_data <= merged;
          acc         <= '0;
        end else begin
          acc <= merged;
        end
      end
    end
  end
endmodule

// File: rtl/rxdesc_close.sv
module rxdesc_close
  import rxdesc_pkg::*;
(
  input  logic [31:0]      held_status,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [LEN_W-1:0] min_len,
  input  logic [LEN_W-1:0] max_len,
  output logic [31:0]      wr_data
);
  logic is_short;
  logic is_long;

  assign is_short = (frame_len < min_len);
  assign is_long  = (frame_len > max_len);
  assign wr_data  = close_status(held_status, frame_len, is_short, is_long);
endmodule

// File: rtl/rxdesc_engine.sv
module rxdesc_engine
  import rxdesc_pkg::*;
#(
  parameter  int BD_WORDS  = 256,
  parameter  int ADDR_W    = 32,
  parameter  int HDR_BYTES = 14,
  localparam int IDX_W     = $clog2(BD_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [15:0]       min_len,
  input  logic [15:0]       max_len,
  input  logic              rxf_mask,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  output logic              rx_ready,
  output logic [IDX_W-1:0]  desc_idx,
  input  logic [31:0]       desc_status,
  input  logic [ADDR_W-1:0] desc_bufaddr,
  output logic              desc_wr_en,
  output logic [31:0]       desc_wr_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic              evt_busy,
  output logic              evt_rxf,
  output logic              irq
);
  rx_state_e         state, state_nx;
  logic [31:0]       held_status;
  logic [ADDR_W-1:0] held_buf;
  logic [LEN_W-1:0]  byte_cnt;

  // named internal events
  logic st_idle;
  logic desc_free;
  logic claim;
  logic accept;
  logic frame_end;
  logic short_drop;

  assign st_idle    = (state == ST_IDLE);
  assign desc_free  = desc_status[OWN_POS];
  assign claim      = (state == ST_SEEK) && desc_free;
  assign rx_ready   = (state == ST_RECV);
  assign accept     = rx_valid && rx_ready;
  assign frame_end  = accept && rx_last;
  assign short_drop = frame_end && ((byte_cnt + LEN_W'(1)) < LEN_W'(HDR_BYTES));

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (rx_enable) state_nx = ST_SEEK;
      ST_SEEK: begin
        if (desc_free)       state_nx = ST_RECV;
        else if (!rx_enable) state_nx = ST_IDLE;
      end
      ST_RECV:  if (frame_end) state_nx = short_drop ? ST_IDLE : ST_CLOSE;
      ST_CLOSE: state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      held_status <= '0;
      held_buf    <= '0;
    end else begin
      state <= state_nx;
      if (claim) begin
        held_status <= claim_status(desc_status);
        held_buf    <= desc_bufaddr;
      end
    end
  end

  rxdesc_index #(
    .BD_WORDS (BD_WORDS),
    .IDX_W    (IDX_W)
  ) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload   (st_idle && !rx_enable),
    .advance  (state == ST_CLOSE),
    .wrap_bit (held_status[WRAP_POS]),
    .base_idx (base_idx),
    .cur_idx  (desc_idx)
  );

  rxdesc_packer #(
    .ADDR_W (ADDR_W)
  ) u_packer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (claim),
    .accept      (accept),
    .byte_in     (rx_data),
    .last_in     (rx_last),
    .buf_addr    (held_buf),
    .byte_cnt    (byte_cnt),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data)
  );

  rxdesc_close u_close (
    .held_status (held_status),
    .frame_len   (byte_cnt),
    .min_len     (min_len),
    .max_len     (max_len),
    .wr_data     (desc_wr_data)
  );

  assign desc_wr_en = (state == ST_CLOSE);
  assign evt_rxf    = desc_wr_en;
  assign irq        = evt_rxf && rxf_mask;
  assign evt_busy   = (state == ST_SEEK) && !desc_free && rx_valid;

endmodule

// File: rtl/rxdesc_engine_chk.sv
module rxdesc_engine_chk #(
  parameter int IDX_W     = 8,
  parameter int HDR_BYTES = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_enable,
  input logic             st_idle,
  input logic             rx_ready,
  input logic             evt_busy,
  input logic             evt_rxf,
  input logic             irq,
  input logic             mem_wr_en,
  input logic [1:0]       mem_addr_lo,
  input logic             desc_wr_en,
  input logic [31:0]      desc_wr_data,
  input logic             short_drop,
  input logic [IDX_W-1:0] desc_idx,
  input logic [IDX_W-1:0] base_idx,
  input logic [15:0]      min_len,
  input logic [15:0]      max_len
);
  AST_CLOSED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && !rx_enable) |=> !rx_ready); // R1

  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_busy |-> (!rx_ready && !desc_wr_en)); // R3

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_addr_lo == 2'b00)); // R4

  AST_OWNER_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |-> !desc_wr_data[15]); // R6

  AST_LIMIT_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wr_en && (min_len <= max_len)) |-> !(desc_wr_data[1] && desc_wr_data[2])); // R7

  AST_SHORT_NOT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    short_drop |=> (!desc_wr_en && !evt_rxf)); // R8

  AST_RELEASED_LEN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |-> (desc_wr_data[31:16] >= 16'(HDR_BYTES))); // R8

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |=> ((desc_idx == $past(desc_idx) + IDX_W'(2)) || (desc_idx == $past(base_idx)))); // R9

  AST_IRQ_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> desc_wr_en); // R10
endmodule

bind rxdesc_engine rxdesc_engine_chk #(
  .IDX_W     (IDX_W),
  .HDR_BYTES (HDR_BYTES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_enable    (rx_enable),
  .st_idle      (st_idle),
  .rx_ready     (rx_ready),
  .evt_busy     (evt_busy),
  .evt_rxf      (evt_rxf),
  .irq          (irq),
  .mem_wr_en    (mem_wr_en),
  .mem_addr_lo  (mem_wr_addr[1:0]),
  .desc_wr_en   (desc_wr_en),
  .desc_wr_data (desc_wr_data),
  .short_drop   (short_drop),
  .desc_idx     (desc_idx),
  .base_idx     (base_idx),
  .min_len      (min_len),
  .max_len      (max_len)
);

// File: tb/tb_rxdesc_engine.sv
`timescale 1ns/1ps
module tb_rxdesc_engine;
  localparam int BDW   = 16;
  localparam int IW    = 4;
  localparam int AW    = 32;
  localparam int MINL  = 16;
  localparam int MAXL  = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_enable = 1'b0;
  logic [IW-1:0] base_idx = 4'd4;
  logic [15:0]   min_len = 16'(MINL);
  logic [15:0]   max_len = 16'(MAXL);
  logic          rxf_mask = 1'b0;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = 8'h00;
  logic          rx_last = 1'b0;
  logic          rx_ready;
  logic [IW-1:0] desc_idx;
  logic [31:0]   desc_status;
  logic [AW-1:0] desc_bufaddr;
  logic          desc_wr_en;
  logic [31:0]   desc_wr_data;
  logic          mem_wr_en;
  logic [AW-1:0] mem_wr_addr;
  logic [31:0]   mem_wr_data;
  logic          evt_busy, evt_rxf, irq;

  logic [31:0] tbl [0:BDW-1];
  logic [31:0] mem [0:255];

  int n_checks = 0;
  int n_errors = 0;
  int n_desc_wr = 0, n_mem_wr = 0, n_busy = 0, n_rxf = 0, n_irq = 0;
  int exp_idx = 4;
  int base_v  = 4;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rxdesc_engine #(.BD_WORDS(BDW), .ADDR_W(AW), .HDR_BYTES(14)) dut (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .base_idx(base_idx),
    .min_len(min_len), .max_len(max_len), .rxf_mask(rxf_mask),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .desc_idx(desc_idx), .desc_status(desc_status), .desc_bufaddr(desc_bufaddr),
    .desc_wr_en(desc_wr_en), .desc_wr_data(desc_wr_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .evt_busy(evt_busy), .evt_rxf(evt_rxf), .irq(irq)
  );

  assign desc_status  = tbl[desc_idx];
  assign desc_bufaddr = tbl[4'(desc_idx + 4'd1)];

  // table, memory and event models
  always @(posedge clk) begin
    if (desc_wr_en) begin tbl[desc_idx] <= desc_wr_data; n_desc_wr <= n_desc_wr + 1; end
    if (mem_wr_en)  begin mem[mem_wr_addr[9:2]] <= mem_wr_data; n_mem_wr <= n_mem_wr + 1; end
    if (evt_busy) n_busy <= n_busy + 1;
    if (evt_rxf)  n_rxf  <= n_rxf + 1;
    if (irq)      n_irq  <= n_irq + 1;
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int seed, input int i);
    return 8'((seed * 13 + i * 7 + 1) & 8'hFF);
  endfunction

  task automatic send_frame(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = byte_of(seed, i);
      rx_last  = (i == len - 1);
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last  = 1'b0;
  endtask

  function automatic logic [31:0] preset(input bit wrap);
    return 32'hFFFF_827F | (wrap ? 32'h0000_2000 : 32'h0);
  endfunction

  task automatic arm(input int idx, input bit wrap);
    int bufw;
    bufw = 64 + idx * 8;
    tbl[idx]     = preset(wrap);
    tbl[idx + 1] = 32'(bufw * 4);
    for (int w = 0; w < 8; w++) mem[bufw + w] = 32'hDEAD_BEEF;
  endtask

  task automatic run_frame(input int len, input int seed, input bit wrap, input bit mask);
    int idx, bufw, nwords, d0, r0, i0, nxt;
    logic [31:0] exp_st, exp_w;
    bit sh, lg;
    idx = exp_idx;
    bufw = 64 + idx * 8;
    @(negedge clk);
    rxf_mask = mask;
    arm(idx, wrap);
    d0 = n_desc_wr; r0 = n_rxf; i0 = n_irq;
    send_frame(len, seed);
    repeat (4) @(negedge clk);
    sh = (len < MINL);
    lg = (len > MAXL);
    exp_st = {16'(len), preset(wrap)[15:0]};
    exp_st[15] = 1'b0;
    exp_st[6:0] = {4'b0, lg, sh, 1'b0};
    check("R6", "status word", tbl[idx], exp_st);
    check("R7", "limit flags", tbl[idx][2:1], {lg, sh});
    nwords = (len + 3) / 4;
    for (int w = 0; w < nwords; w++) begin
      exp_w = '0;
      for (int b = 0; b < 4; b++)
        if (w * 4 + b < len) exp_w[31 - 8*b -: 8] = byte_of(seed, w * 4 + b);
      check((w == nwords - 1 && (len % 4) != 0) ? "R5" : "R4", "memory word", mem[bufw + w], exp_w);
    end
    check("R5", "word past end untouched", mem[bufw + nwords], 32'hDEAD_BEEF);
    nxt = (wrap || idx >= BDW - 2) ? base_v : idx + 2;
    check("R9", "next index", desc_idx, nxt);
    check("R10", "one write-back and rxf", (n_desc_wr - d0) * 16 + (n_rxf - r0), 17);
    check("R10", "irq count vs mask", n_irq - i0, mask ? 1 : 0);
    exp_idx = nxt;
  endtask

  initial begin
    for (int i = 0; i < BDW; i++) tbl[i] = 32'h0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // reset / disabled state
    check("R1", "rx_ready while disabled", rx_ready, 0);
    check("R1", "desc_wr_en while disabled", desc_wr_en, 0);
    check("R1", "irq while disabled", irq, 0);
    rx_valid = 1'b1; rx_data = 8'hA5;
    repeat (5) @(negedge clk);
    check("R1", "no activity while disabled", n_busy + n_mem_wr + n_desc_wr, 0);
    check("R2", "index follows base", desc_idx, 4);
    // enable with no free descriptor: busy
    rx_enable = 1'b1;
    repeat (10) @(negedge clk);
    check("R3", "busy raised while waiting", (n_busy >= 8) ? 1 : 0, 1);
    check("R3", "no claim of owned descriptor", rx_ready, 0);
    check("R2", "first descriptor at base", desc_idx, 4);
    rx_valid = 1'b0;
    @(negedge clk);
    begin
      int b0;
      b0 = n_busy;
      repeat (3) @(negedge clk);
      check("R3", "busy stops without pending frame", n_busy - b0, 0);
    end
    // sweep lengths across all lanes and both limits
    for (int n = 0; n < 12; n++) begin
      run_frame(14 + n, n, (n == 2), (n < 6));
      if (n == 5) begin
        int d0, r0, idx;
        idx = exp_idx;
        @(negedge clk);
        arm(idx, 1'b0);
        d0 = n_desc_wr; r0 = n_rxf;
        send_frame(9, 77);
        repeat (4) @(negedge clk);
        check("R8", "short frame keeps status", tbl[idx], preset(1'b0));
        check("R8", "short frame no write-back", n_desc_wr - d0, 0);
        check("R8", "short frame no rxf", n_rxf - r0, 0);
        check("R8", "short frame keeps index", desc_idx, idx);
      end
    end
    // disable, move base, re-enable
    @(negedge clk);
    rx_enable = 1'b0;
    base_idx  = 4'd6;
    base_v    = 6;
    repeat (4) @(negedge clk);
    check("R1", "rx_ready low after disable", rx_ready, 0);
    check("R2", "index reloaded from new base", desc_idx, 6);
    rx_enable = 1'b1;
    exp_idx = 6;
    repeat (2) @(negedge clk);
    run_frame(20, 99, 1'b0, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule